// File: doc/BRIEF.md
# PCIe Uncorrectable Error Status Logger

This block holds the 32-bit uncorrectable-error status word of a PCI Express endpoint. It also holds a 128-bit header capture register. Error detectors in the physical, data-link and transaction layers send it single-cycle pulses. The block turns each pulse into a sticky status bit, and software clears a bit by writing 1 to it. A few bits have set conditions of their own:

- The link-training bit watches the current and previous LTSSM state for specific moves into Detect.
- The surprise-down bit responds to a link-down event only when the capability enable is high.
- The internal-error bit merges parity, RAM ECC and an external client input.

Four transaction-layer error types also capture the header of the offending TLP. The first header is kept until software clears the status bits that caused the capture.

The block drives two summary outputs, fatal and non-fatal, for the error-message logic. The register port is a plain read/write strobe interface with no back-pressure: a write takes effect at the clock edge where `reg_wr_en` is high. A read answers exactly one cycle later, flagged by `reg_rd_valid`. No mask input exists: masking happens downstream and never affects capture.

Top module: `uerr_status_log`

## Requirements
- R1: The status word is read at offset 0x104. The header log is read at offsets 0x11C, 0x120, 0x124 and 0x128, which return header bits 31:0, 63:32, 95:64 and 127:96. Any other offset reads 0. Status bits 3:1, 11:6, 21 and 31:23 always read 0, and writes to any offset other than 0x104 change nothing.
- R2: After reset, every status bit, the header log, `reg_rd_valid`, `err_fatal` and `err_nonfatal` are 0.
- R3: A pulse sets its status bit on the next clock edge. The pulses map to bits as follows: data-link protocol 4, poisoned TLP 12, flow-control protocol 13, completion timeout 14, completer abort 15, unexpected completion 16, receiver overflow 17, malformed TLP 18, ECRC 19, unsupported request 20. A set bit stays set until it is cleared.
- R4: A write to 0x104 clears every implemented bit where the write data holds a 1. Bits where the write data holds a 0 are left unchanged.
- R5: If a set pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up 1.
- R6: Bit 0 is set when `ltssm_prev` is Configuration (0x02) or Recovery (0x04) and `ltssm_cur` is Detect (0x00). Any other previous state, such as Polling (0x01) or L0 (0x10), moving into Detect leaves bit 0 alone.
- R7: Bit 5 is set by `link_down_evt` only while `sdown_cap_en` is 1. With the enable at 0, a link-down event has no effect.
- R8: Bit 22 is set by `int_parity_err`, `ram_ecc_err` or `ext_uncorr_err`.
- R9: A cycle with a poisoned TLP, completer abort, malformed TLP or unsupported request pulse captures `tlp_hdr` into the header log, provided the log is free.
- R10: After a capture the log is held, and later header-logging errors do not overwrite it. The log frees once every status bit whose pulse caused the capture is cleared. A header-logging pulse in the same cycle as that clear captures the new header.
- R11: `err_fatal` is 1 whenever bit 18 or bit 22 is set. `err_nonfatal` is 1 whenever any other implemented bit is set. Both follow the status word in the cycle after it changes.
- R12: A read strobe at one clock edge raises `reg_rd_valid` after that edge, with `reg_rdata` holding the value the addressed register had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ltssm_cur | input | 5 | Current LTSSM state |
| ltssm_prev | input | 5 | LTSSM state of the previous cycle |
| link_down_evt | input | 1 | Link-up to link-down event pulse |
| sdown_cap_en | input | 1 | Surprise-down reporting capability enable |
| dl_proto_err | input | 1 | Data-link protocol error pulse |
| poisoned_tlp | input | 1 | Poisoned TLP received |
| fc_proto_err | input | 1 | Flow-control protocol violation |
| cpl_timeout | input | 1 | Completion timer expired |
| cpl_abort | input | 1 | Completer abort returned |
| unexp_cpl | input | 1 | Unexpected completion received |
| rx_overflow | input | 1 | TLP received beyond available credit |
| malformed_tlp | input | 1 | Malformed TLP received |
| ecrc_err | input | 1 | End-to-end CRC error |
| unsup_req | input | 1 | Unsupported request received |
| int_parity_err | input | 1 | Internal parity error |
| ram_ecc_err | input | 1 | Uncorrectable RAM ECC error |
| ext_uncorr_err | input | 1 | Client-signalled uncorrectable error |
| tlp_hdr | input | 128 | Header of the TLP tied to this cycle's pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| err_fatal | output | 1 | Some fatal-severity bit is set |
| err_nonfatal | output | 1 | Some non-fatal-severity bit is set |

## Verification
The hardest situation to reach from the ports is the header-log hand-off: a write clears the last cause bit in the same cycle that a new header-logging error arrives. A close second is a set and a clear colliding on one bit. A directed sequence builds both cases on purpose, using a capture whose cause is a single bit and then a clear paired with a fresh pulse. The random phase writes often, with dense write data, and fires events at a steady rate, so collisions and lock releases happen many times. A bench model tracks the expected status, lock and header, and every read is compared against it.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned B_LTE  = 0;
  localparam int unsigned B_DLP  = 4;
  localparam int unsigned B_SDN  = 5;
  localparam int unsigned B_PSN  = 12;
  localparam int unsigned B_FCP  = 13;
  localparam int unsigned B_CTO  = 14;
  localparam int unsigned B_CAB  = 15;
  localparam int unsigned B_UXC  = 16;
  localparam int unsigned B_ROV  = 17;
  localparam int unsigned B_MAL  = 18;
  localparam int unsigned B_ECRC = 19;
  localparam int unsigned B_UNS  = 20;
  localparam int unsigned B_INT  = 22;

  // implemented bits, fatal-by-default bits, header-logging bits
  localparam logic [REG_W-1:0] IMPL_MASK  = 32'h005F_F031;
  localparam logic [REG_W-1:0] FATAL_MASK = 32'h0044_0000;
  localparam logic [REG_W-1:0] HDR_MASK   = 32'h0014_9000;

  typedef struct packed {
    logic dl_proto;
    logic poisoned;
    logic fc_proto;
    logic cpl_tmo;
    logic cpl_abort;
    logic unexp_cpl;
    logic rx_ovf;
    logic malformed;
    logic ecrc;
    logic unsup_req;
  } uerr_evt_t;
endpackage

// File: rtl/uerr_ltssm_det.sv
module uerr_ltssm_det #(
  parameter int unsigned          STATE_W  = 5,
  parameter logic [STATE_W-1:0]   ST_DET   = 5'h00,
  parameter logic [STATE_W-1:0]   ST_CFG   = 5'h02,
  parameter logic [STATE_W-1:0]   ST_REC   = 5'h04
) (
  input  logic [STATE_W-1:0] cur,
  input  logic [STATE_W-1:0] prev,
  output logic               train_fail
);
  logic into_detect;
  logic from_cfg_rec;

  always_comb begin
    into_detect  = (cur == ST_DET);
    from_cfg_rec = (prev == ST_CFG) || (prev == ST_REC);
    train_fail   = into_detect && from_cfg_rec;
  end
endmodule

// File: rtl/uerr_event_map.sv
module uerr_event_map
  import uerr_pkg::*;
(
  input  uerr_evt_t          evt,
  input  logic               train_fail,
  input  logic               link_down_evt,
  input  logic               sdown_cap_en,
  input  logic               int_parity_err,
  input  logic               ram_ecc_err,
  input  logic               ext_uncorr_err,
  output logic [REG_W-1:0]   set_vec
);
  always_comb begin
    set_vec         = '0;
    set_vec[B_LTE]  = train_fail;
    set_vec[B_DLP]  = evt.dl_proto;
    set_vec[B_SDN]  = link_down_evt && sdown_cap_en;
    set_vec[B_PSN]  = evt.poisoned;
    set_vec[B_FCP]  = evt.fc_proto;
    set_vec[B_CTO]  = evt.cpl_tmo;
    set_vec[B_CAB]  = evt.cpl_abort;
    set_vec[B_UXC]  = evt.unexp_cpl;
    set_vec[B_ROV]  = evt.rx_ovf;
    set_vec[B_MAL]  = evt.malformed;
    set_vec[B_ECRC] = evt.ecrc;
    set_vec[B_UNS]  = evt.unsup_req;
    set_vec[B_INT]  = int_parity_err || ram_ecc_err || ext_uncorr_err;
  end
endmodule

// File: rtl/uerr_status_bits.sv
module uerr_status_bits #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status_q
);
  // set has priority over a write-1 clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (set_vec | (status_q & ~clr_vec)) & IMPL;
  end
endmodule

// File: rtl/uerr_hdr_log.sv
module uerr_hdr_log #(
  parameter int unsigned W     = 32,
  parameter int unsigned HDR_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     hdr_evt,
  input  logic [W-1:0]     status_q,
  input  logic [W-1:0]     clr_vec,
  input  logic [HDR_W-1:0] hdr_in,
  output logic [HDR_W-1:0] hdr_q,
  output logic             cap_pulse
);
  logic         locked_q;
  logic [W-1:0] cause_q;
  logic         free;

  always_comb begin
    free      = !locked_q || ((status_q & ~clr_vec & cause_q) == '0);
    cap_pulse = free && (|hdr_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q    <= '0;
      cause_q  <= '0;
      locked_q <= 1'b0;
    end else if (cap_pulse) begin
      hdr_q    <= hdr_in;
      cause_q  <= hdr_evt;
      locked_q <= 1'b1;
    end else if (free) begin
      locked_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uerr_regport.sv
module uerr_regport #(
  parameter int unsigned          ADDR_W   = 12,
  parameter int unsigned          W        = 32,
  parameter int unsigned          HDR_W    = 128,
  parameter logic [ADDR_W-1:0]    STAT_OFF = 12'h104,
  parameter logic [ADDR_W-1:0]    HDR_OFF  = 12'h11C,
  parameter logic [W-1:0]         IMPL     = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      status_q,
  input  logic [HDR_W-1:0]  hdr_q,
  output logic [W-1:0]      clr_vec,
  output logic [W-1:0]      rdata,
  output logic              rd_valid
);
  localparam int unsigned HDR_WORDS = HDR_W / W;
  localparam int unsigned BYTES_W   = W / 8;

  logic [HDR_WORDS-1:0] hdr_hit;
  logic [W-1:0]         hdr_word [HDR_WORDS];
  logic [W-1:0]         rd_mux;

  for (genvar gw = 0; gw < HDR_WORDS; gw++) begin : g_hdr_word
    localparam logic [ADDR_W-1:0] WOFF = HDR_OFF + ADDR_W'(gw * BYTES_W);
    assign hdr_hit[gw]  = (addr == WOFF);
    assign hdr_word[gw] = hdr_q[gw*W +: W];
  end

  always_comb begin
    clr_vec = (wr_en && addr == STAT_OFF) ? (wdata & IMPL) : '0;
    rd_mux  = '0;
    if (addr == STAT_OFF) rd_mux = status_q;
    for (int i = 0; i < HDR_WORDS; i++) begin
      if (hdr_hit[i]) rd_mux = hdr_word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/uerr_status_log.sv
module uerr_status_log
  import uerr_pkg::*;
#(
  parameter int unsigned        STATE_W  = 5,
  parameter logic [STATE_W-1:0] ST_DET   = 5'h00,
  parameter logic [STATE_W-1:0] ST_CFG   = 5'h02,
  parameter logic [STATE_W-1:0] ST_REC   = 5'h04,
  parameter int unsigned        HDR_W    = 128,
  parameter int unsigned        ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]  STAT_OFF = 12'h104,
  parameter logic [ADDR_W-1:0]  HDR_OFF  = 12'h11C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ltssm_cur,
  input  logic [STATE_W-1:0] ltssm_prev,
  input  logic               link_down_evt,
  input  logic               sdown_cap_en,
  input  logic               dl_proto_err,
  input  logic               poisoned_tlp,
  input  logic               fc_proto_err,
  input  logic               cpl_timeout,
  input  logic               cpl_abort,
  input  logic               unexp_cpl,
  input  logic               rx_overflow,
  input  logic               malformed_tlp,
  input  logic               ecrc_err,
  input  logic               unsup_req,
  input  logic               int_parity_err,
  input  logic               ram_ecc_err,
  input  logic               ext_uncorr_err,
  input  logic [HDR_W-1:0]   tlp_hdr,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               reg_rd_valid,
  output logic               err_fatal,
  output logic               err_nonfatal
);
  uerr_evt_t        evt;
  logic             train_fail;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] status_q;
  logic [HDR_W-1:0] hdr_q;
  logic             cap_pulse;

  always_comb begin
    evt.dl_proto  = dl_proto_err;
    evt.poisoned  = poisoned_tlp;
    evt.fc_proto  = fc_proto_err;
    evt.cpl_tmo   = cpl_timeout;
    evt.cpl_abort = cpl_abort;
    evt.unexp_cpl = unexp_cpl;
    evt.rx_ovf    = rx_overflow;
    evt.malformed = malformed_tlp;
    evt.ecrc      = ecrc_err;
    evt.unsup_req = unsup_req;
  end

  uerr_ltssm_det #(
    .STATE_W(STATE_W), .ST_DET(ST_DET), .ST_CFG(ST_CFG), .ST_REC(ST_REC)
  ) u_ltssm (
    .cur(ltssm_cur), .prev(ltssm_prev), .train_fail(train_fail)
  );

  uerr_event_map u_map (
    .evt(evt), .train_fail(train_fail), .link_down_evt(link_down_evt),
    .sdown_cap_en(sdown_cap_en), .int_parity_err(int_parity_err),
    .ram_ecc_err(ram_ecc_err), .ext_uncorr_err(ext_uncorr_err),
    .set_vec(set_vec)
  );

  uerr_status_bits #(.W(REG_W), .IMPL(IMPL_MASK)) u_bits (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .status_q(status_q)
  );

  uerr_hdr_log #(.W(REG_W), .HDR_W(HDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .hdr_evt(set_vec & HDR_MASK),
    .status_q(status_q), .clr_vec(clr_vec), .hdr_in(tlp_hdr),
    .hdr_q(hdr_q), .cap_pulse(cap_pulse)
  );

  uerr_regport #(
    .ADDR_W(ADDR_W), .W(REG_W), .HDR_W(HDR_W),
    .STAT_OFF(STAT_OFF), .HDR_OFF(HDR_OFF), .IMPL(IMPL_MASK)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .status_q(status_q), .hdr_q(hdr_q),
    .clr_vec(clr_vec), .rdata(reg_rdata), .rd_valid(reg_rd_valid)
  );

  always_comb begin
    err_fatal    = |(status_q & FATAL_MASK);
    err_nonfatal = |(status_q & IMPL_MASK & ~FATAL_MASK);
  end
endmodule

// File: rtl/uerr_status_chk.sv
module uerr_status_chk #(
  parameter int unsigned HDR_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      set_vec,
  input logic [31:0]      clr_vec,
  input logic [31:0]      status_q,
  input logic [HDR_W-1:0] hdr_q,
  input logic             cap_pulse,
  input logic             sdown_cap_en,
  input logic             err_fatal,
  input logic             reg_rd_en,
  input logic             reg_rd_valid
);
  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((status_q & $past(clr_vec & ~set_vec)) == 32'h0));

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == 32'h0 && set_vec == 32'h0) |=> $stable(status_q));

  assert_set_beats_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & clr_vec)) |=> ((status_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  assert_sdown_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sdown_cap_en |=> (!status_q[5] || $past(status_q[5])));

  assert_hdr_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse |=> $stable(hdr_q));

  assert_fatal_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_fatal) |-> $past(set_vec[18] || set_vec[22]));

  assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid);
endmodule

bind uerr_status_log uerr_status_chk #(.HDR_W(HDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
  .status_q(status_q), .hdr_q(hdr_q), .cap_pulse(cap_pulse),
  .sdown_cap_en(sdown_cap_en), .err_fatal(err_fatal),
  .reg_rd_en(reg_rd_en), .reg_rd_valid(reg_rd_valid)
);

// File: tb/uerr_status_log_test.sv
`timescale 1ns/1ps
module uerr_status_log_test;
  localparam logic [11:0] A_ST = 12'h104;
  localparam logic [31:0] IMPL = 32'h005F_F031;
  localparam logic [31:0] FAT  = 32'h0044_0000;
  localparam logic [31:0] HDRM = 32'h0014_9000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ltssm_cur, ltssm_prev;
  logic link_down_evt, sdown_cap_en, dl_proto_err, poisoned_tlp, fc_proto_err;
  logic cpl_timeout, cpl_abort, unexp_cpl, rx_overflow, malformed_tlp, ecrc_err;
  logic unsup_req, int_parity_err, ram_ecc_err, ext_uncorr_err;
  logic [127:0] tlp_hdr;
  logic reg_wr_en, reg_rd_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic reg_rd_valid, err_fatal, err_nonfatal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0]  m_st;
  logic [127:0] m_hdr;
  logic         m_lk;
  logic [31:0]  m_cause;

  always #4 clk = ~clk;

  uerr_status_log uut (
    .clk(clk), .rst_n(rst_n), .ltssm_cur(ltssm_cur), .ltssm_prev(ltssm_prev),
    .link_down_evt(link_down_evt), .sdown_cap_en(sdown_cap_en),
    .dl_proto_err(dl_proto_err), .poisoned_tlp(poisoned_tlp),
    .fc_proto_err(fc_proto_err), .cpl_timeout(cpl_timeout), .cpl_abort(cpl_abort),
    .unexp_cpl(unexp_cpl), .rx_overflow(rx_overflow), .malformed_tlp(malformed_tlp),
    .ecrc_err(ecrc_err), .unsup_req(unsup_req), .int_parity_err(int_parity_err),
    .ram_ecc_err(ram_ecc_err), .ext_uncorr_err(ext_uncorr_err), .tlp_hdr(tlp_hdr),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rd_valid(reg_rd_valid),
    .err_fatal(err_fatal), .err_nonfatal(err_nonfatal)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ltssm_cur = 5'h10; ltssm_prev = 5'h10;
    {link_down_evt, dl_proto_err, poisoned_tlp, fc_proto_err, cpl_timeout,
     cpl_abort, unexp_cpl, rx_overflow, malformed_tlp, ecrc_err, unsup_req,
     int_parity_err, ram_ecc_err, ext_uncorr_err} = '0;
    reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = A_ST; reg_wdata = '0;
  endtask

  function automatic logic [31:0] f_set();
    logic [31:0] s = '0;
    s[0]  = (ltssm_cur == 5'h00) && (ltssm_prev == 5'h02 || ltssm_prev == 5'h04);
    s[4]  = dl_proto_err;
    s[5]  = link_down_evt && sdown_cap_en;
    s[12] = poisoned_tlp;   s[13] = fc_proto_err;  s[14] = cpl_timeout;
    s[15] = cpl_abort;      s[16] = unexp_cpl;     s[17] = rx_overflow;
    s[18] = malformed_tlp;  s[19] = ecrc_err;      s[20] = unsup_req;
    s[22] = int_parity_err || ram_ecc_err || ext_uncorr_err;
    return s;
  endfunction

  function automatic logic [31:0] f_read(input logic [11:0] a);
    case (a)
      12'h104: return m_st;
      12'h11C: return m_hdr[31:0];
      12'h120: return m_hdr[63:32];
      12'h124: return m_hdr[95:64];
      12'h128: return m_hdr[127:96];
      default: return 32'h0;
    endcase
  endfunction

  // one clock: model update, then check outputs after the edge
  task automatic step(input string tag);
    logic [31:0] exp_rd, s, c, h;
    bit do_rd, free;
    do_rd  = reg_rd_en;
    exp_rd = f_read(reg_addr);
    s = f_set();
    c = (reg_wr_en && reg_addr == A_ST) ? (reg_wdata & IMPL) : 32'h0;
    h = s & HDRM;
    free = !m_lk || ((m_st & ~c & m_cause) == 32'h0);
    if (free && (|h)) begin
      m_hdr = tlp_hdr; m_lk = 1'b1; m_cause = h;
    end else if (free) begin
      m_lk = 1'b0;
    end
    m_st = (m_st & ~c) | s;
    @(posedge clk);
    @(negedge clk);
    if (do_rd) begin
      chk(reg_rd_valid === 1'b1, "R12 rd_valid", {31'b0, reg_rd_valid}, 32'h1);
      chk(reg_rdata === exp_rd, tag, reg_rdata, exp_rd);
    end
    chk(err_fatal === (|(m_st & FAT)), "R11 fatal", {31'b0, err_fatal}, {31'b0, |(m_st & FAT)});
    chk(err_nonfatal === (|(m_st & IMPL & ~FAT)), "R11 nonfatal",
        {31'b0, err_nonfatal}, {31'b0, |(m_st & IMPL & ~FAT)});
    idle();
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    reg_rd_en = 1'b1; reg_addr = a;
    step(tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    step(tag);
  endtask

  function automatic logic [11:0] pick_addr(input int k);
    case (k % 8)
      0, 1, 2: return 12'h104;
      3: return 12'h11C;
      4: return 12'h120;
      5: return 12'h124;
      6: return 12'h128;
      default: return 12'h108;
    endcase
  endfunction

  function automatic string addr_tag(input logic [11:0] a);
    if (a == 12'h104) return "R3 status";
    if (a >= 12'h11C && a <= 12'h128) return "R9 header";
    return "R1 unmapped";
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7734));
    idle();
    sdown_cap_en = 1'b0;
    tlp_hdr = '0;
    m_st = '0; m_hdr = '0; m_lk = 1'b0; m_cause = '0;
    repeat (3) @(negedge clk);
    chk(reg_rd_valid === 1'b0, "R2 rd_valid in reset", {31'b0, reg_rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({err_fatal, err_nonfatal} === 2'b00, "R2 summaries", {30'b0, err_fatal, err_nonfatal}, 32'h0);
    rd(12'h104, "R2 status after reset");
    rd(12'h11C, "R2 header after reset");

    // R6: Polling->Detect ignored, Configuration->Detect and Recovery->Detect set
    ltssm_prev = 5'h01; ltssm_cur = 5'h00; step("R6");
    rd(12'h104, "R6 polling to detect");
    ltssm_prev = 5'h02; ltssm_cur = 5'h00; step("R6");
    rd(12'h104, "R6 config to detect");
    chk(reg_rdata[0] === 1'b1, "R6 bit0", reg_rdata, 32'h1);
    wr(A_ST, 32'h1, "R4");
    ltssm_prev = 5'h04; ltssm_cur = 5'h00; step("R6");
    rd(12'h104, "R6 recovery to detect");

    // R7: link down gated by capability
    sdown_cap_en = 1'b0; link_down_evt = 1'b1; step("R7");
    rd(12'h104, "R7 link down no cap");
    chk(reg_rdata[5] === 1'b0, "R7 bit5 clear", reg_rdata, 32'h0);
    sdown_cap_en = 1'b1; link_down_evt = 1'b1; step("R7");
    rd(12'h104, "R7 link down with cap");

    // R8: each internal source
    ext_uncorr_err = 1'b1; step("R8");
    rd(12'h104, "R8 external");
    chk(err_fatal === 1'b1, "R11 fatal after bit22", {31'b0, err_fatal}, 32'h1);
    wr(A_ST, 32'h0040_0000, "R4");
    ram_ecc_err = 1'b1; step("R8");
    rd(12'h104, "R8 ecc");
    wr(A_ST, 32'h0000_0000, "R4 write zero");
    rd(12'h104, "R4 write zero keeps");
    wr(12'h100, 32'hFFFF_FFFF, "R1 stray write");
    rd(12'h104, "R1 stray write ignored");
    wr(A_ST, 32'hFFFF_FFFF, "R4 clear all");
    rd(12'h104, "R4 all cleared");
    chk(reg_rdata === 32'h0, "R4 zero", reg_rdata, 32'h0);

    // R5: set wins
    poisoned_tlp = 1'b1; tlp_hdr = {4{32'hA5A5_0001}}; step("R9");
    poisoned_tlp = 1'b1; reg_wr_en = 1'b1; reg_addr = A_ST; reg_wdata = 32'h0000_1000;
    step("R5");
    rd(12'h104, "R5 set beats clear");
    chk(reg_rdata[12] === 1'b1, "R5 bit12", reg_rdata, 32'h1000);

    // R10: lock, hold, release in same cycle as new capture
    wr(A_ST, 32'hFFFF_FFFF, "R4");
    poisoned_tlp = 1'b1; tlp_hdr = {32'h4, 32'h3, 32'h2, 32'h1}; step("R9");
    malformed_tlp = 1'b1; tlp_hdr = {4{32'hDEAD_BEEF}}; step("R10");
    rd(12'h11C, "R10 first kept w0");
    rd(12'h128, "R10 first kept w3");
    chk(reg_rdata === 32'h4, "R10 literal", reg_rdata, 32'h4);
    reg_wr_en = 1'b1; reg_addr = A_ST; reg_wdata = 32'h0000_1000;
    unsup_req = 1'b1; tlp_hdr = {32'hC4, 32'hC3, 32'hC2, 32'hC1};
    step("R10");
    rd(12'h11C, "R10 handoff capture");
    chk(reg_rdata === 32'hC1, "R10 new header", reg_rdata, 32'hC1);
    wr(A_ST, 32'hFFFF_FFFF, "R4");

    // random phase
    for (int it = 0; it < 3000; it++) begin
      dl_proto_err   = ($urandom_range(19) == 0);
      poisoned_tlp   = ($urandom_range(19) == 0);
      fc_proto_err   = ($urandom_range(19) == 0);
      cpl_timeout    = ($urandom_range(19) == 0);
      cpl_abort      = ($urandom_range(19) == 0);
      unexp_cpl      = ($urandom_range(19) == 0);
      rx_overflow    = ($urandom_range(19) == 0);
      malformed_tlp  = ($urandom_range(29) == 0);
      ecrc_err       = ($urandom_range(19) == 0);
      unsup_req      = ($urandom_range(19) == 0);
      int_parity_err = ($urandom_range(49) == 0);
      ram_ecc_err    = ($urandom_range(49) == 0);
      ext_uncorr_err = ($urandom_range(49) == 0);
      link_down_evt  = ($urandom_range(19) == 0);
      sdown_cap_en   = $urandom_range(1);
      if ($urandom_range(9) == 0) begin
        ltssm_cur = 5'h00;
        case ($urandom_range(3))
          0: ltssm_prev = 5'h01;
          1: ltssm_prev = 5'h02;
          2: ltssm_prev = 5'h04;
          default: ltssm_prev = 5'h10;
        endcase
      end
      tlp_hdr = {$urandom, $urandom, $urandom, $urandom};
      reg_rd_en = 1'b1;
      reg_addr  = pick_addr($urandom_range(7));
      if ($urandom_range(2) == 0) begin
        reg_wr_en = 1'b1;
        reg_addr  = ($urandom_range(7) == 0) ? 12'h100 : A_ST;
        reg_wdata = ($urandom_range(3) == 0) ? 32'hFFFF_FFFF : $urandom;
      end
      step(addr_tag(reg_addr));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule